// File: doc/BRIEF.md
# Modular LFSR Update Unit

This block keeps the sixteen-cell state of a word-oriented stream-cipher keystream generator. Each cell is 31 bits wide and holds a residue modulo the prime 2^31-1. On every enabled step the unit computes one fresh cell from a weighted sum of five taps. In initialization mode it also adds the upper 31 bits of an externally supplied 32-bit word W. The register then shifts by one cell, and the fresh value enters at the top.

The sum is formed by a tree of 3:2 carry-save compressors. Each compressor rotates its carry vector left by one position, which gives an end-around carry modulo 2^31-1. A single carry-propagate adder with a folded carry finishes the sum. Scaling by a power of two modulo 2^31-1 is a rotation, so the tap weights cost no logic. A synchronous load writes all sixteen cells in one cycle. Four 32-bit output words are wired from halves of selected cells. Three of them feed a nonlinear function outside the block, and the fourth feeds keystream generation.

Top module: `lfsr_mod_update`

## Requirements
- R1: A synchronous active-high reset clears all sixteen cells to zero, so all four output words read 0 after reset.
- R2: When `load_en` is high, all sixteen cells are written at the next clock edge. Cell i takes `load_data[31*i +: 31]`.
- R3: A step moves the state down by one cell: each cell i below 15 takes the old value of cell i+1, and cell 15 takes the newly computed value.
- R4: In working mode (`init_mode` = 0) the new value is (2^15·c15 + 2^17·c13 + 2^21·c10 + 2^20·c4 + 257·c0) mod (2^31-1). In this mode `w_in` has no effect.
- R5: In initialization mode (`init_mode` = 1) the value `w_in[31:1]` is added to the R4 sum before the reduction modulo 2^31-1. Bit 0 of `w_in` has no effect.
- R6: A modular result of zero is stored as 2^31-1, so a step never writes zero into cell 15.
- R7: With neither `load_en` nor `step_en` high, the state holds whatever `init_mode` and `w_in` are.
- R8: When `load_en` and `step_en` are both high, the load takes effect and the step is discarded.
- R9: The output words are x0 = {c15[30:15], c14[15:0]}, x1 = {c11[15:0], c9[30:15]}, x2 = {c7[15:0], c5[30:15]} and x3 = {c2[15:0], c0[30:15]}. Each is a pure function of the registered cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write all cells from `load_data` |
| load_data | input | 496 | Sixteen 31-bit cell values, cell 0 in the low bits |
| step_en | input | 1 | Advance the register by one cell |
| init_mode | input | 1 | 1 = add `w_in[31:1]` to the new value, 0 = working mode |
| w_in | input | 32 | Nonlinear-function output word |
| x0 | output | 32 | Reorganized word from cells 15 and 14 |
| x1 | output | 32 | Reorganized word from cells 11 and 9 |
| x2 | output | 32 | Reorganized word from cells 7 and 5 |
| x3 | output | 32 | Reorganized word from cells 2 and 0 |

## Verification
A load and a step can be requested in the same cycle. The bench raises both enables together, with a fresh load pattern and an active W word, and expects the output words to show the loaded cells and no trace of a step. Zero replacement and the highest carry pressure can meet in one step. The bench drives this by stepping from all-zero cells with W = 1, where the W term vanishes because bit 0 is dropped. It also steps from all-ones cells with W all ones. In both cases a behavioural model that uses plain integer modulo arithmetic judges the result on every clock.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int CELL_W  = 31;
  localparam int N_CELLS = 16;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam logic [CELL_W-1:0] ALL_ONES = '1;

  typedef logic [CELL_W-1:0] cell_t;

  // Multiply by 2^k modulo 2^CELL_W-1 is a left rotation by k.
  function automatic cell_t rotl(input cell_t v, input int k);
    cell_t r;
    for (int i = 0; i < CELL_W; i++) r[(i + k) % CELL_W] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/csa_mod.sv
module csa_mod
  import lfsr_pkg::*;
(
  input  cell_t a,
  input  cell_t b,
  input  cell_t c,
  output cell_t sum,
  output cell_t carry
);
  cell_t maj;
  always_comb begin
    sum   = a ^ b ^ c;
    maj   = (a & b) | (a & c) | (b & c);
    // carry weight doubles: rotate so bit 30 wraps to bit 0
    carry = {maj[CELL_W-2:0], maj[CELL_W-1]};
  end
endmodule

// File: rtl/mod_sum_tree.sv
module mod_sum_tree
  import lfsr_pkg::*;
(
  input  cell_t             c0,
  input  cell_t             c4,
  input  cell_t             c10,
  input  cell_t             c13,
  input  cell_t             c15,
  input  logic              init_mode,
  input  logic [WORD_W-1:0] w_in,
  output cell_t             result
);
  localparam int N_OPS = 7;
  cell_t ops [N_OPS];
  cell_t s1a, k1a, s1b, k1b, s2, k2, s3, k3, s4, k4;
  logic [CELL_W:0]   wide;
  cell_t             folded;

  always_comb begin
    ops[0] = rotl(c15, 15);
    ops[1] = rotl(c13, 17);
    ops[2] = rotl(c10, 21);
    ops[3] = rotl(c4, 20);
    ops[4] = rotl(c0, 8);
    ops[5] = c0;
    ops[6] = init_mode ? w_in[WORD_W-1:1] : '0;
  end

  // level 1: 7 -> 5
  csa_mod u_l1a (.a(ops[0]), .b(ops[1]), .c(ops[2]), .sum(s1a), .carry(k1a));
  csa_mod u_l1b (.a(ops[3]), .b(ops[4]), .c(ops[5]), .sum(s1b), .carry(k1b));
  // level 2: 5 -> 4
  csa_mod u_l2  (.a(s1a), .b(k1a), .c(s1b), .sum(s2), .carry(k2));
  // level 3: 4 -> 3
  csa_mod u_l3  (.a(k1b), .b(ops[6]), .c(s2), .sum(s3), .carry(k3));
  // level 4: 3 -> 2
  csa_mod u_l4  (.a(k2), .b(s3), .c(k3), .sum(s4), .carry(k4));

  // single carry-propagate add, carry-out folded back in
  always_comb begin
    wide   = {1'b0, s4} + {1'b0, k4};
    folded = wide[CELL_W-1:0] + cell_t'(wide[CELL_W]);
    result = (folded == '0) ? ALL_ONES : folded;
  end
endmodule

// File: rtl/lfsr_mod_update.sv
module lfsr_mod_update
  import lfsr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_en,
  input  logic [N_CELLS*CELL_W-1:0] load_data,
  input  logic                      step_en,
  input  logic                      init_mode,
  input  logic [WORD_W-1:0]         w_in,
  output logic [WORD_W-1:0]         x0,
  output logic [WORD_W-1:0]         x1,
  output logic [WORD_W-1:0]         x2,
  output logic [WORD_W-1:0]         x3
);
  localparam int TOP = N_CELLS - 1;
  localparam longint unsigned MODV = (64'd1 << CELL_W) - 1;

  logic [N_CELLS-1:0][CELL_W-1:0] cells;
  cell_t fresh;

  mod_sum_tree u_tree (
    .c0(cells[0]), .c4(cells[4]), .c10(cells[10]), .c13(cells[13]),
    .c15(cells[15]), .init_mode(init_mode), .w_in(w_in), .result(fresh)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    cell_t nxt;
    if (i == TOP) begin : g_top
      assign nxt = fresh;
    end else begin : g_mid
      assign nxt = cells[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)          cells[i] <= '0;
      else if (load_en) cells[i] <= load_data[i*CELL_W +: CELL_W];
      else if (step_en) cells[i] <= nxt;
    end
  end

  assign x0 = {cells[15][CELL_W-1 -: HALF_W], cells[14][HALF_W-1:0]};
  assign x1 = {cells[11][HALF_W-1:0], cells[9][CELL_W-1 -: HALF_W]};
  assign x2 = {cells[7][HALF_W-1:0],  cells[5][CELL_W-1 -: HALF_W]};
  assign x3 = {cells[2][HALF_W-1:0],  cells[0][CELL_W-1 -: HALF_W]};

  // integer-arithmetic reference used only by the assertions below
  function automatic cell_t ref_next(input logic [N_CELLS-1:0][CELL_W-1:0] c,
                                     input logic im, input logic [WORD_W-1:0] w);
    longint unsigned acc;
    acc = ((longint'(c[15]) << 15) % MODV) + ((longint'(c[13]) << 17) % MODV)
        + ((longint'(c[10]) << 21) % MODV) + ((longint'(c[4]) << 20) % MODV)
        + ((longint'(c[0]) * 257) % MODV);
    if (im) acc = acc + longint'(w >> 1);
    acc = acc % MODV;
    if (acc == 0) acc = MODV;
    return acc[CELL_W-1:0];
  endfunction

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cells == $past(load_data));
  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> cells[0] == $past(cells[1]));
  p_value_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> cells[15] == $past(ref_next(cells, init_mode, w_in)));
  p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> cells[15] != '0);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> $stable(cells));
endmodule

// File: tb/sim_lfsr_mod_update.sv
module sim_lfsr_mod_update;
  localparam longint unsigned M = 64'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0, step_en = 1'b0, init_mode = 1'b0;
  logic [495:0] load_data = '0;
  logic [31:0] w_in = '0;
  logic [31:0] x0, x1, x2, x3;

  int checks = 0, errors = 0;
  longint unsigned m [16];
  longint unsigned ldv [16];

  always #2.5 clk = ~clk;

  lfsr_mod_update u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .step_en(step_en), .init_mode(init_mode), .w_in(w_in),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3)
  );

  function automatic longint unsigned mnext(bit im, logic [31:0] w);
    longint unsigned acc;
    acc = ((m[15] << 15) % M) + ((m[13] << 17) % M) + ((m[10] << 21) % M)
        + ((m[4] << 20) % M) + ((m[0] * 257) % M);
    if (im) acc += longint'(w) / 2;
    acc = acc % M;
    return (acc == 0) ? M : acc;
  endfunction

  function automatic logic [31:0] hi(longint unsigned v); return 32'((v >> 15) & 16'hFFFF); endfunction
  function automatic logic [31:0] lo(longint unsigned v); return 32'(v & 16'hFFFF); endfunction

  task automatic compare(input string tag);
    logic [31:0] e0, e1, e2, e3;
    e0 = (hi(m[15]) << 16) | lo(m[14]);
    e1 = (lo(m[11]) << 16) | hi(m[9]);
    e2 = (lo(m[7])  << 16) | hi(m[5]);
    e3 = (lo(m[2])  << 16) | hi(m[0]);
    checks++;
    if ({x0, x1, x2, x3} !== {e0, e1, e2, e3}) begin
      errors++;
      $display("FAIL %s: x0..x3 = %h %h %h %h, expected %h %h %h %h",
               tag, x0, x1, x2, x3, e0, e1, e2, e3);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 16; i++) ldv[i] = longint'($urandom) & M;
  endtask

  task automatic fill_const(longint unsigned v);
    for (int i = 0; i < 16; i++) ldv[i] = v;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit ld, input bit st, input bit im,
                     input logic [31:0] w, input string tag);
    longint unsigned n;
    load_en = ld; step_en = st; init_mode = im; w_in = w;
    for (int i = 0; i < 16; i++) load_data[i*31 +: 31] = ldv[i][30:0];
    @(posedge clk);
    if (ld) begin
      for (int i = 0; i < 16; i++) m[i] = ldv[i];
    end else if (st) begin
      n = mnext(im, w);
      for (int i = 0; i < 15; i++) m[i] = m[i+1];
      m[15] = n;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m[i] = 0; ldv[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");
    // R6: zero cells in working mode give zero -> stored as all ones
    cyc(0, 1, 0, 32'h0, "R6 zero replaced (working)");
    // R6/R5: all-zero cells, W=1 in init mode: bit 0 dropped, zero result
    fill_const(0);
    cyc(1, 0, 0, 32'h0, "R2 load zeros");
    cyc(0, 1, 1, 32'h1, "R6 R5 zero replaced, W bit0 ignored");
    // R2 R9: random load visible on the output words
    fill_random();
    cyc(1, 0, 1, $urandom, "R2 R9 random load");
    // R3 R4: working steps with random W that must not matter
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, $urandom, "R3 R4 working step");
    // R5: initialization steps
    fill_random();
    cyc(1, 0, 0, 32'h0, "R2 reload");
    for (int i = 0; i < 40; i++) cyc(0, 1, 1, $urandom, "R5 init step");
    // R7: idle with changing mode and W
    for (int i = 0; i < 10; i++) cyc(0, 0, i[0], $urandom, "R7 hold");
    // R8: load and step together
    fill_random();
    cyc(1, 1, 1, 32'hFFFF_FFFF, "R8 load beats step");
    cyc(0, 1, 0, 32'h0, "R3 step after R8");
    // carry pressure: all-ones cells with all-ones W
    fill_const(M);
    cyc(1, 0, 0, 32'h0, "R2 load all ones");
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 32'hFFFF_FFFF, "R5 R4 max operands");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) fill_random();
      cyc(r == 0, r > 3, ($urandom % 2) == 1, $urandom, "R3 R9 mixed");
    end
    rst = 1'b1;
    for (int i = 0; i < 16; i++) m[i] = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    compare("R1 reset after traffic");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule